// File: doc/BRIEF.md
# Interleaved Bank Command Issuer for Random Burst Reads

This block turns a stream of fixed-size random read requests into a command stream for an eight-bank DRAM device. It issues exactly one command per command clock: an idle slot (NOP), a row open (ACT), or a burst read that closes its row by itself once the data is out (RDA). Every read uses that self-closing form, so no separate close command ever takes a slot on the command bus. One burst of eight 32-bit words (32 bytes) needs two command clocks on the data bus. The block fills the gap between two reads with an ACT to a different bank, so the next row is opening while the current burst is still moving.

Requests arrive through a valid/ready handshake that carries bank, row and column. They are accepted strictly in arrival order. A request whose bank is still open, or is still closing, holds the handshake low until that bank is free again. The block applies four rules, each set by a build-time parameter: the minimum spacing between any two ACTs, a rolling window that limits how many ACTs it may contain, the delay from ACT to READ on the same bank, and the time from a bank's READ until that bank may open a row again. It also keeps READs far enough apart that their bursts never overlap.

Top module: `bank_cmd_sched`

## Requirements
- R1: While rst_n is low, cmdCode is NOP (2'b00) and reqReady is low.
- R2: Command codes are 2'b00 NOP, 2'b01 ACT and 2'b10 READ with auto-precharge. For ACT, cmdAddr carries the row. For READ, cmdAddr carries the column, zero-extended. Every accepted request produces exactly one ACT to its bank and row, followed later by exactly one READ to its bank and column.
- R3: Two ACT commands are at least TRRD command clocks apart.
- R4: Any TFAW consecutive command clocks contain at most FAW_ACTS ACT commands.
- R5: A READ to a bank comes at least TRCD clocks after that bank's ACT, and only while that bank is open.
- R6: After a READ, its bank receives no ACT for TPRE clocks. With nothing else pending, the next ACT to that bank comes exactly TPRE clocks after the READ.
- R7: READs are at least BURST_CLK clocks apart. When a READ is legal it takes the slot ahead of any ACT, so ready reads run back to back.
- R8: Requests are accepted and activated in arrival order. A request to a bank that is open or still precharging is held with reqReady low until that bank is free.
- R9: In any slot with no legal command, and whenever the block is idle, cmdCode is NOP.
- R10: A stream of requests that rotates over all banks runs at the limit set by the ACT window. Read k of the stream comes TFAW*(k/FAW_ACTS)+TRRD*(k%FAW_ACTS) clocks after read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | A request is presented |
| reqReady | output | 1 | The request is accepted at this edge |
| reqBank | input | 3 | Target bank |
| reqRow | input | 14 | Row to open |
| reqCol | input | 7 | Column of the burst |
| cmdCode | output | 2 | 00 NOP, 01 ACT, 10 READ with auto-precharge |
| cmdBank | output | 3 | Bank of the command |
| cmdAddr | output | 14 | Row for ACT, column for READ |

## Verification
The bench builds the block with TRRD=2, TFAW=10, FAW_ACTS=4, TRCD=5, TPRE=8 and BURST_CLK=2. Because four ACTs at the minimum spacing fit inside the ten-clock window, the window limit really does bind. A rotating stream therefore settles into a fixed pattern of four back-to-back reads in every ten clocks, which the bench predicts exactly. TRCD+TPRE=13 is shorter than one full rotation over the eight banks, so stalls appear only when a bank repeats. That makes the exact reopen delay and the handshake hold time measurable in a directed case. A long random run checks every spacing rule for every command against a bench-side model and scoreboard.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RDA = 2'b10
  } cmd_e;

  typedef struct packed {
    logic doAct;
    logic doRead;
  } strobe_t;
endpackage

// File: rtl/sched_dp.sv
module sched_dp
  import sched_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 7,
  parameter int QDEPTH    = 4,
  parameter int TRRD      = 2,
  parameter int BURST_CLK = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  strobe_t                      strobe,
  input  logic [$clog2(NUM_BANKS)-1:0] reqBank,
  input  logic [ROW_W-1:0]             reqRow,
  input  logic [COL_W-1:0]             reqCol,
  output logic                         headValid,
  output logic [$clog2(NUM_BANKS)-1:0] headBank,
  output logic                         qFull,
  output logic [1:0]                   cmdCode,
  output logic [$clog2(NUM_BANKS)-1:0] cmdBank,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] cmdAddr
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int PTR_W  = $clog2(QDEPTH);
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  // FIFO of activated requests waiting for their READ slot
  logic [BANK_W-1:0] qBank [QDEPTH];
  logic [COL_W-1:0]  qCol  [QDEPTH];
  logic [PTR_W:0]    wrPtr, rdPtr;
  cmd_e              cmdQ;

  assign headValid = (wrPtr != rdPtr);
  assign qFull     = (wrPtr[PTR_W] != rdPtr[PTR_W]) &&
                     (wrPtr[PTR_W-1:0] == rdPtr[PTR_W-1:0]);
  assign headBank  = qBank[rdPtr[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (strobe.doAct) begin
      qBank[wrPtr[PTR_W-1:0]] <= reqBank;
      qCol[wrPtr[PTR_W-1:0]]  <= reqCol;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.doAct)  wrPtr <= wrPtr + 1'b1;
      if (strobe.doRead) rdPtr <= rdPtr + 1'b1;
    end
  end

  // registered command slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdQ    <= CMD_NOP;
      cmdBank <= '0;
      cmdAddr <= '0;
    end else if (strobe.doRead) begin
      cmdQ    <= CMD_RDA;
      cmdBank <= headBank;
      cmdAddr <= ADDR_W'(qCol[rdPtr[PTR_W-1:0]]);
    end else if (strobe.doAct) begin
      cmdQ    <= CMD_ACT;
      cmdBank <= reqBank;
      cmdAddr <= ADDR_W'(reqRow);
    end else begin
      cmdQ    <= CMD_NOP;
      cmdBank <= '0;
      cmdAddr <= '0;
    end
  end

  assign cmdCode = cmdQ;

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doAct |-> !qFull);
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doRead |-> headValid);

  if (TRRD > 1) begin : g_rrdChk
    p_act_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmdQ == CMD_ACT) |=> (cmdQ != CMD_ACT));
  end
  if (BURST_CLK > 1) begin : g_gapChk
    p_read_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmdQ == CMD_RDA) |=> (cmdQ != CMD_RDA));
  end
endmodule

// File: rtl/sched_ctl.sv
module sched_ctl
  import sched_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TRRD      = 2,
  parameter int TFAW      = 10,
  parameter int FAW_ACTS  = 4,
  parameter int TRCD      = 5,
  parameter int TPRE      = 8,
  parameter int BURST_CLK = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reqValid,
  input  logic [$clog2(NUM_BANKS)-1:0] reqBank,
  input  logic                         headValid,
  input  logic [$clog2(NUM_BANKS)-1:0] headBank,
  input  logic                         qFull,
  output logic                         reqReady,
  output strobe_t                      strobe
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int RCD_W  = $clog2(TRCD + 1);
  localparam int PRE_W  = $clog2(TPRE + 1);
  localparam int RRD_W  = $clog2(TRRD + 1);
  localparam int GAP_W  = $clog2(BURST_CLK + 1);
  localparam int HIST_W = TFAW - 1;

  logic [NUM_BANKS-1:0] bankOpen, bankIdle, rcdDone;
  logic [RRD_W-1:0]     rrdCnt;
  logic [GAP_W-1:0]     gapCnt;
  logic [HIST_W-1:0]    actHist;   // ACT marks of the last TFAW-1 slots
  logic                 readOk, fawOk;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [RCD_W-1:0] rcdCnt;
    logic [PRE_W-1:0] preCnt;
    logic             actHit, rdHit;

    assign actHit = strobe.doAct  && (reqBank  == BANK_W'(b));
    assign rdHit  = strobe.doRead && (headBank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bankOpen[b] <= 1'b0;
        rcdCnt      <= '0;
        preCnt      <= '0;
      end else begin
        if (actHit) begin
          bankOpen[b] <= 1'b1;
          rcdCnt      <= RCD_W'(TRCD - 1);
        end else if (rcdCnt != 0) begin
          rcdCnt <= rcdCnt - 1'b1;
        end
        if (rdHit) begin
          bankOpen[b] <= 1'b0;
          preCnt      <= PRE_W'(TPRE - 1);
        end else if (preCnt != 0) begin
          preCnt <= preCnt - 1'b1;
        end
      end
    end

    assign bankIdle[b] = !bankOpen[b] && (preCnt == 0);
    assign rcdDone[b]  = (rcdCnt == 0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrdCnt  <= '0;
      gapCnt  <= '0;
      actHist <= '0;
    end else begin
      if (strobe.doAct)     rrdCnt <= RRD_W'(TRRD - 1);
      else if (rrdCnt != 0) rrdCnt <= rrdCnt - 1'b1;
      if (strobe.doRead)    gapCnt <= GAP_W'(BURST_CLK - 1);
      else if (gapCnt != 0) gapCnt <= gapCnt - 1'b1;
      actHist <= {actHist[HIST_W-2:0], strobe.doAct};
    end
  end

  always_comb begin
    fawOk  = ($countones(actHist) < FAW_ACTS);
    readOk = headValid && bankOpen[headBank] && rcdDone[headBank] && (gapCnt == 0);
    reqReady = rst_n && !readOk && !qFull && bankIdle[reqBank] &&
               (rrdCnt == 0) && fawOk;
    strobe.doRead = readOk;
    strobe.doAct  = reqValid && reqReady;
  end

  p_read_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doRead |-> bankOpen[headBank]);
  p_act_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doAct |-> !bankOpen[reqBank]);
endmodule

// File: rtl/bank_cmd_sched.sv
module bank_cmd_sched
  import sched_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 7,
  parameter int QDEPTH    = 4,
  parameter int TRRD      = 2,
  parameter int TFAW      = 10,
  parameter int FAW_ACTS  = 4,
  parameter int TRCD      = 5,
  parameter int TPRE      = 8,
  parameter int BURST_CLK = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic [$clog2(NUM_BANKS)-1:0] reqBank,
  input  logic [ROW_W-1:0]             reqRow,
  input  logic [COL_W-1:0]             reqCol,
  output logic [1:0]                   cmdCode,
  output logic [$clog2(NUM_BANKS)-1:0] cmdBank,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] cmdAddr
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  strobe_t           strobe;
  logic              headValid, qFull;
  logic [BANK_W-1:0] headBank;

  sched_ctl #(
    .NUM_BANKS(NUM_BANKS), .TRRD(TRRD), .TFAW(TFAW), .FAW_ACTS(FAW_ACTS),
    .TRCD(TRCD), .TPRE(TPRE), .BURST_CLK(BURST_CLK)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqBank(reqBank),
    .headValid(headValid), .headBank(headBank), .qFull(qFull),
    .reqReady(reqReady), .strobe(strobe)
  );

  sched_dp #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .QDEPTH(QDEPTH),
    .TRRD(TRRD), .BURST_CLK(BURST_CLK)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .headValid(headValid),
    .headBank(headBank), .qFull(qFull), .cmdCode(cmdCode),
    .cmdBank(cmdBank), .cmdAddr(cmdAddr)
  );
endmodule

// File: tb/bank_cmd_sched_tb.sv
module bank_cmd_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8, ROW_W = 14, COL_W = 7;
  localparam int TRRD = 2, TFAW = 10, FAW_ACTS = 4, TRCD = 5, TPRE = 8, BURST_CLK = 2;

  logic clk = 1'b0, rst_n = 1'b0, reqValid = 1'b0, reqReady;
  logic [2:0] reqBank = '0, cmdBank;
  logic [ROW_W-1:0] reqRow = '0, cmdAddr;
  logic [COL_W-1:0] reqCol = '0;
  logic [1:0] cmdCode;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_cmd_sched #(
    .NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W), .QDEPTH(4), .TRRD(TRRD),
    .TFAW(TFAW), .FAW_ACTS(FAW_ACTS), .TRCD(TRCD), .TPRE(TPRE), .BURST_CLK(BURST_CLK)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdAddr(cmdAddr)
  );

  typedef struct { int bank; int row; int col; } req_t;

  int total = 0, bad = 0;
  longint cyc = 0;
  req_t actQ[$], rdQ[$];
  longint actLog[$], rdLog[$];
  bit isOpen[NB];
  longint actAt[NB], readyAt[NB];
  longint lastAct = -1000, lastRead = -1000;

  task automatic chk(input bit ok, input string tag, input longint actual, input longint expect_);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expect_);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor and scoreboard: every command is checked against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmdCode == 2'b01) begin
        req_t e;
        chk(actQ.size() > 0, "R2 ACT without request", actQ.size(), 1);
        if (actQ.size() > 0) begin
          e = actQ.pop_front();
          chk(int'(cmdBank) == e.bank && int'(cmdAddr) == e.row, "R8 ACT order bank/row",
              {cmdBank, cmdAddr}, {e.bank[2:0], e.row[ROW_W-1:0]});
        end
        chk(cyc - lastAct >= TRRD, "R3 ACT spacing", cyc - lastAct, TRRD);
        if (actLog.size() >= FAW_ACTS)
          chk(cyc - actLog[actLog.size()-FAW_ACTS] >= TFAW, "R4 ACT window",
              cyc - actLog[actLog.size()-FAW_ACTS], TFAW);
        chk(!isOpen[cmdBank] && cyc >= readyAt[cmdBank], "R6 ACT to busy bank",
            cyc, readyAt[cmdBank]);
        isOpen[cmdBank] = 1'b1;
        actAt[cmdBank] = cyc;
        lastAct = cyc;
        actLog.push_back(cyc);
      end else if (cmdCode == 2'b10) begin
        req_t e;
        chk(rdQ.size() > 0, "R2 READ without request", rdQ.size(), 1);
        if (rdQ.size() > 0) begin
          e = rdQ.pop_front();
          chk(int'(cmdBank) == e.bank && int'(cmdAddr) == e.col, "R2 READ bank/col",
              {cmdBank, cmdAddr}, {e.bank[2:0], e.col[ROW_W-1:0]});
        end
        chk(isOpen[cmdBank] && cyc - actAt[cmdBank] >= TRCD, "R5 READ after ACT",
            cyc - actAt[cmdBank], TRCD);
        chk(cyc - lastRead >= BURST_CLK, "R7 READ spacing", cyc - lastRead, BURST_CLK);
        isOpen[cmdBank] = 1'b0;
        readyAt[cmdBank] = cyc + TPRE;
        lastRead = cyc;
        rdLog.push_back(cyc);
      end else begin
        chk(cmdCode == 2'b00, "R2 illegal code", cmdCode, 0);
      end
    end
  end

  // driver: presents a request at a negedge, returns at the negedge after acceptance
  task automatic sendReq(input int b, input int r, input int c, output int waits);
    bit acc;
    req_t e;
    waits = 0;
    reqValid = 1'b1;
    reqBank = 3'(b); reqRow = ROW_W'(r); reqCol = COL_W'(c);
    do begin
      #(CLK_PERIOD/2 - 1);
      acc = reqReady;
      if (acc) begin
        e.bank = b; e.row = r; e.col = c;
        actQ.push_back(e);
        rdQ.push_back(e);
      end else begin
        waits++;
      end
      @(negedge clk);
    end while (!acc);
  endtask

  task automatic idleWait(input int n);
    reqValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w, n0, r0;
    for (int i = 0; i < NB; i++) begin
      isOpen[i] = 1'b0; actAt[i] = -1000; readyAt[i] = 0;
    end
    // R1: reset state while a request is offered
    reqValid = 1'b1; reqBank = 3'd2;
    repeat (4) @(negedge clk);
    chk(cmdCode == 2'b00, "R1 cmd NOP in reset", cmdCode, 0);
    chk(reqReady == 1'b0, "R1 ready low in reset", reqReady, 0);
    reqValid = 1'b0;
    rst_n = 1'b1;
    idleWait(3);
    chk(cmdCode == 2'b00, "R9 idle NOP after reset", cmdCode, 0);

    // R5 single request: READ exactly TRCD after ACT
    sendReq(3, 14'h155, 7'h2A, w);
    idleWait(20);
    chk(rdLog.size() == 1 && actLog.size() == 1, "R2 one ACT one READ", rdLog.size(), 1);
    chk(rdLog[0] - actLog[0] == TRCD, "R5 minimal ACT-READ delay", rdLog[0] - actLog[0], TRCD);
    chk(cmdCode == 2'b00, "R9 NOP when drained", cmdCode, 0);

    // R6/R8: same bank twice, then another bank
    n0 = actLog.size(); r0 = rdLog.size();
    sendReq(5, 1, 1, w);
    sendReq(5, 2, 2, w);
    chk(w == TRCD + TPRE - 1, "R8 ready held while bank busy", w, TRCD + TPRE - 1);
    sendReq(1, 3, 3, w);
    idleWait(20);
    chk(actLog[n0+1] - rdLog[r0] == TPRE, "R6 reopen delay", actLog[n0+1] - rdLog[r0], TPRE);
    chk(actLog.size() - n0 == 3, "R8 all activated", actLog.size() - n0, 3);

    // R10/R7: rotating stream, window-limited rate
    r0 = rdLog.size();
    for (int k = 0; k < 40; k++) sendReq(k % NB, 100 + k, k, w);
    idleWait(30);
    chk(rdLog.size() - r0 == 40, "R10 read count", rdLog.size() - r0, 40);
    chk(rdLog[r0+39] - rdLog[r0] == TFAW * (39 / FAW_ACTS) + TRRD * (39 % FAW_ACTS),
        "R10 stream span", rdLog[r0+39] - rdLog[r0], TFAW * (39 / FAW_ACTS) + TRRD * (39 % FAW_ACTS));
    chk(rdLog[r0+1] - rdLog[r0] == BURST_CLK, "R7 gapless reads", rdLog[r0+1] - rdLog[r0], BURST_CLK);

    // random load spread over the banks
    for (int k = 0; k < 300; k++)
      sendReq(int'($urandom_range(0, NB-1)), int'($urandom_range(0, 16383)),
              int'($urandom_range(0, 127)), w);
    idleWait(40);
    chk(actQ.size() == 0, "R2 all requests activated", actQ.size(), 0);
    chk(rdQ.size() == 0, "R2 all requests read", rdQ.size(), 0);
    chk(cmdCode == 2'b00, "R9 NOP at end", cmdCode, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule